// File: doc/BRIEF.md
# Receive Frame Status Word Builder

This block follows one received frame at a time. A start strobe opens the frame. Data bytes and side-band events arrive while the frame is open, and an end strobe closes it. From the byte count, from the contents of a few header bytes and from the events, it assembles the 32-bit status word that a receive engine writes back to the host when the frame ends. Each status bit has its own validity rule, so a bit is raised only under the conditions where it is meaningful.

The block does not compute the CRC or filter addresses. It takes a CRC-good flag and an address-match flag as inputs and samples both in the end cycle, together with the no-buffer and receive-all inputs. The finished word and a one-cycle done strobe appear in the cycle after the end strobe. The word then holds until the next frame completes.

Top module: `rxs_builder`

## Requirements
- R1: After reset, `status` is zero and `done` is low. `done` pulses high for exactly one cycle, in the cycle after an accepted `eof`. An `eof` is accepted only while a frame is open: after a `sof` and not yet closed by an `eof`. An `eof` outside a frame produces no pulse and leaves `status` unchanged.
- R2: In the `sof` cycle, all frame state is cleared and that cycle's byte and event inputs are ignored. Bytes with `byte_vld` high are counted from the next cycle up to and including the `eof` cycle. Idle cycles inside the frame add nothing.
- R3: Bits [29:16] hold the byte count, which saturates at 16383. The field is zero when bit 14 (no buffer) is set.
- R4: Bit 11 (runt) is set when the count is below 64. Bit 7 (too long) is set when the count is above 1518. Bit 0 is set when either of them is set.
- R5: Bit 6 (late collision) is set when `coll` is high in a cycle in which more than 64 bytes have already been counted. A collision at 64 bytes or fewer leaves bit 6 clear.
- R6: Bit 5 (type frame) is set when the count is at least 14 and the big-endian value of bytes 12 and 13 (0-based) is above 1500. Otherwise it is clear.
- R7: Bit 1 (CRC error) is set when `crc_ok` is low in the `eof` cycle, except for runt frames.
- R8: Bit 30 (filter fail) is set only when `rx_all` is high, `addr_match` is low and the count is at least 64. Both inputs are sampled in the `eof` cycle.
- R9: Bit 14 mirrors `no_buf` in the `eof` cycle. Bit 15 is the OR of bits 1, 6, 7, 11 and 14.
- R10: Bit 10 (multicast) is bit 0 of byte 0. Bit 3 records any `phy_err` and bit 2 any `dribble` seen during the frame. All other bits are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sof | input | 1 | Start-of-frame strobe |
| eof | input | 1 | End-of-frame strobe; may carry the last byte |
| byte_vld | input | 1 | Byte present on `byte_data` |
| byte_data | input | 8 | Received byte |
| phy_err | input | 1 | Physical layer error event |
| coll | input | 1 | Collision event |
| dribble | input | 1 | Frame ended off a byte boundary |
| crc_ok | input | 1 | External CRC check passed (sampled at `eof`) |
| addr_match | input | 1 | Address filter passed (sampled at `eof`) |
| no_buf | input | 1 | No receive buffer was available (sampled at `eof`) |
| rx_all | input | 1 | Receive-all mode (sampled at `eof`) |
| status | output | 32 | Receive status word |
| done | output | 1 | One-cycle strobe, status is new |

## Verification
A wrong internal state can only show up in the status word of the next completed frame. A byte counter that is off by one moves the length field and flips the runt, too-long, filter-fail and type bits at the 14, 64 and 1518 boundaries. A stale sticky event flag or a frame-open flag left set leaks into the following frame's word, or makes a stray done pulse appear. Because of this, the bench places frames exactly on every threshold and runs them back to back, and it compares `done` and `status` against its model on every clock. A fault is therefore reported no later than one cycle after the frame's `eof`.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
    localparam int WORD_W = 32;

    typedef struct packed {
        logic        filt_fail;
        logic [13:0] length;
        logic        no_buf;
        logic        runt;
        logic        mcast;
        logic        too_long;
        logic        late_coll;
        logic        type_frame;
        logic        phy_err;
        logic        dribble;
        logic        crc_err;
        logic        bad_len;
    } rxs_flags_t;

    function automatic logic [WORD_W-1:0] pack_word(input rxs_flags_t f);
        logic [WORD_W-1:0] w;
        w         = '0;
        w[30]     = f.filt_fail;
        w[29:16]  = f.length;
        w[15]     = f.crc_err | f.late_coll | f.too_long | f.runt | f.no_buf;
        w[14]     = f.no_buf;
        w[11]     = f.runt;
        w[10]     = f.mcast;
        w[7]      = f.too_long;
        w[6]      = f.late_coll;
        w[5]      = f.type_frame;
        w[3]      = f.phy_err;
        w[2]      = f.dribble;
        w[1]      = f.crc_err;
        w[0]      = f.bad_len;
        return w;
    endfunction
endpackage

// File: rtl/rxs_count.sv
module rxs_count #(
    parameter int LEN_W    = 14,
    parameter int TYPE_OFS = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             take,
    input  logic [7:0]       byte_data,
    output logic [LEN_W-1:0] len_q,
    output logic [LEN_W-1:0] len_d,
    output logic             mcast_d,
    output logic [15:0]      ltype_d
);
    localparam logic [LEN_W-1:0] LEN_MAX = '1;

    logic       mcast_q;
    logic [7:0] lt_hi_q, lt_lo_q, lt_hi_d, lt_lo_d;

    always_comb begin
        len_d   = len_q;
        mcast_d = mcast_q;
        lt_hi_d = lt_hi_q;
        lt_lo_d = lt_lo_q;
        if (take) begin
            if (len_q != LEN_MAX) len_d = len_q + 1'b1;
            if (len_q == '0) mcast_d = byte_data[0];
            if (len_q == LEN_W'(TYPE_OFS)) lt_hi_d = byte_data;
            if (len_q == LEN_W'(TYPE_OFS + 1)) lt_lo_d = byte_data;
        end
        ltype_d = {lt_hi_d, lt_lo_d};
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            len_q   <= '0;
            mcast_q <= 1'b0;
            lt_hi_q <= '0;
            lt_lo_q <= '0;
        end else begin
            len_q   <= len_d;
            mcast_q <= mcast_d;
            lt_hi_q <= lt_hi_d;
            lt_lo_q <= lt_lo_d;
        end
    end

    // R3
    len_sat_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && len_q == LEN_MAX) |=> (len_q == LEN_MAX || $past(clr) || $past(rst)));
endmodule

// File: rtl/rxs_events.sv
module rxs_events #(
    parameter int LEN_W   = 14,
    parameter int MIN_LEN = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             act,
    input  logic [LEN_W-1:0] len_q,
    input  logic             coll,
    input  logic             phy_err,
    input  logic             dribble,
    output logic             late_d,
    output logic             phy_d,
    output logic             drib_d
);
    logic late_q, phy_q, drib_q;

    always_comb begin
        late_d = late_q | (act & coll & (len_q > LEN_W'(MIN_LEN)));
        phy_d  = phy_q  | (act & phy_err);
        drib_d = drib_q | (act & dribble);
    end

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            late_q <= 1'b0;
            phy_q  <= 1'b0;
            drib_q <= 1'b0;
        end else begin
            late_q <= late_d;
            phy_q  <= phy_d;
            drib_q <= drib_d;
        end
    end

    // R5
    early_coll_chk: assert property (@(posedge clk) disable iff (rst)
        (!clr && !late_q && len_q <= LEN_W'(MIN_LEN)) |=> !late_q || $past(clr));
endmodule

// File: rtl/rxs_builder.sv
module rxs_builder
    import rxs_pkg::*;
#(
    parameter int LEN_W    = 14,
    parameter int MIN_LEN  = 64,
    parameter int MAX_LEN  = 1518,
    parameter int TYPE_THR = 1500,
    parameter int TYPE_OFS = 12
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        sof,
    input  logic        eof,
    input  logic        byte_vld,
    input  logic [7:0]  byte_data,
    input  logic        phy_err,
    input  logic        coll,
    input  logic        dribble,
    input  logic        crc_ok,
    input  logic        addr_match,
    input  logic        no_buf,
    input  logic        rx_all,
    output logic [31:0] status,
    output logic        done
);
    localparam int HDR_LEN = TYPE_OFS + 2;

    logic             in_frame;
    logic             act, fin;
    logic [LEN_W-1:0] len_q, len_d;
    logic             mcast_d, late_d, phy_d, drib_d;
    logic [15:0]      ltype_d;
    rxs_flags_t       fl;

    assign act = in_frame && !sof;
    assign fin = act && eof;

    rxs_count #(.LEN_W(LEN_W), .TYPE_OFS(TYPE_OFS)) u_count (
        .clk(clk), .rst(rst), .clr(sof), .take(act && byte_vld),
        .byte_data(byte_data), .len_q(len_q), .len_d(len_d),
        .mcast_d(mcast_d), .ltype_d(ltype_d)
    );

    rxs_events #(.LEN_W(LEN_W), .MIN_LEN(MIN_LEN)) u_events (
        .clk(clk), .rst(rst), .clr(sof), .act(act), .len_q(len_q),
        .coll(coll), .phy_err(phy_err), .dribble(dribble),
        .late_d(late_d), .phy_d(phy_d), .drib_d(drib_d)
    );

    always_comb begin
        fl            = '0;
        fl.runt       = len_d < LEN_W'(MIN_LEN);
        fl.too_long   = len_d > LEN_W'(MAX_LEN);
        fl.bad_len    = fl.runt | fl.too_long;
        fl.no_buf     = no_buf;
        fl.length     = no_buf ? '0 : 14'(len_d);
        fl.late_coll  = late_d;
        fl.type_frame = (len_d >= LEN_W'(HDR_LEN)) && (ltype_d > 16'(TYPE_THR));
        fl.crc_err    = !crc_ok && !fl.runt;
        fl.filt_fail  = rx_all && !addr_match && !fl.runt;
        fl.mcast      = (len_d != '0) && mcast_d;
        fl.phy_err    = phy_d;
        fl.dribble    = drib_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            in_frame <= 1'b0;
            status   <= '0;
            done     <= 1'b0;
        end else begin
            done <= fin;
            if (sof) in_frame <= 1'b1;
            else if (eof) in_frame <= 1'b0;
            if (fin) status <= pack_word(fl);
        end
    end

    // R1
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);
    // R1
    done_cause_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(eof) && !$past(sof));
    // R7
    runt_crc_chk: assert property (@(posedge clk) disable iff (rst)
        done && status[11] |-> !status[1] && !status[30]);
    // R9
    summary_chk: assert property (@(posedge clk) disable iff (rst)
        done && !status[1] && !status[6] && !status[7] && !status[11] && !status[14]
        |-> !status[15]);
    // R1
    hold_chk: assert property (@(posedge clk) disable iff (rst)
        !done && !$past(rst) |-> $stable(status));
endmodule

// File: tb/tb_rxs_builder.sv
module tb_rxs_builder;
    logic        clk = 1'b0;
    logic        rst;
    logic        sof, eof, byte_vld, phy_err, coll, dribble;
    logic        crc_ok, addr_match, no_buf, rx_all;
    logic [7:0]  byte_data;
    logic [31:0] status;
    logic        done;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    int due    = -1;
    logic [31:0] exp_word = '0;
    string       exp_tag  = "R1";

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    rxs_builder dut (
        .clk(clk), .rst(rst), .sof(sof), .eof(eof), .byte_vld(byte_vld),
        .byte_data(byte_data), .phy_err(phy_err), .coll(coll), .dribble(dribble),
        .crc_ok(crc_ok), .addr_match(addr_match), .no_buf(no_buf), .rx_all(rx_all),
        .status(status), .done(done)
    );

    // per-clock comparison against the model
    always @(negedge clk) begin
        if (rst === 1'b0) begin
            checks++;
            if (done !== (due == cyc)) begin
                fails++;
                $display("FAIL R1 done actual=%0b expected=%0b cyc=%0d", done, due == cyc, cyc);
            end
            checks++;
            if (status !== exp_word) begin
                fails++;
                $display("FAIL %s status actual=%h expected=%h", exp_tag, status, exp_word);
            end
        end
    end

    task automatic idle();
        @(posedge clk); #1;
        sof = 0; eof = 0; byte_vld = 0; coll = 0; phy_err = 0; dribble = 0;
    endtask

    // behavioural model of one frame's status word
    function automatic logic [31:0] model(int len, logic [7:0] first, int lt, int coll_at,
                                         logic pe, logic dr, logic ck, logic am,
                                         logic nb, logic ra);
        int L = (len > 16383) ? 16383 : len;
        logic rf = L < 64, tl = L > 1518, cs, ft, ce, de;
        logic [31:0] w = '0;
        cs = (coll_at > 64) && (coll_at < len);
        ft = (L >= 14) && (lt > 1500);
        ce = !ck && !rf;
        de = nb;
        w[30] = ra && !am && !rf;
        w[29:16] = de ? 14'd0 : 14'(L);
        w[15] = ce | cs | tl | rf | de;
        w[14] = de; w[11] = rf; w[10] = (L >= 1) && first[0];
        w[7] = tl; w[6] = cs; w[5] = ft; w[3] = pe; w[2] = dr; w[1] = ce;
        w[0] = rf | tl;
        return w;
    endfunction

    task automatic frame(string tag, int len, logic [7:0] first, int lt, int coll_at,
                         logic pe, logic dr, logic ck, logic am, logic nb, logic ra,
                         logic gap);
        logic [31:0] w;
        w = model(len, first, lt, coll_at, pe, dr, ck, am, nb, ra);
        idle();
        sof = 1; byte_vld = 1; byte_data = 8'hFF; coll = 1; phy_err = 0; // R2 ignored
        for (int i = 0; i < len; i++) begin
            idle();
            if (gap && i == 5) idle();
            byte_vld = 1;
            byte_data = (i == 0) ? first : (i == 12) ? 8'(lt >> 8) :
                        (i == 13) ? 8'(lt) : 8'(i);
            coll = (i == coll_at);
            phy_err = pe && (i == 3);
            dribble = dr && (i == len - 1);
            if (i == len - 1) begin
                eof = 1; crc_ok = ck; addr_match = am; no_buf = nb; rx_all = ra;
                due = cyc + 1;
            end
        end
        if (len == 0) begin
            idle();
            eof = 1; crc_ok = ck; addr_match = am; no_buf = nb; rx_all = ra;
            due = cyc + 1;
        end
        @(posedge clk); #1;
        sof = 0; eof = 0; byte_vld = 0; coll = 0; phy_err = 0; dribble = 0;
        exp_word = w; exp_tag = tag;
        @(posedge clk); #1;
    endtask

    initial begin
        rst = 1; sof = 0; eof = 0; byte_vld = 0; byte_data = 0; phy_err = 0;
        coll = 0; dribble = 0; crc_ok = 1; addr_match = 1; no_buf = 0; rx_all = 0;
        repeat (3) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        checks++;
        if (status !== 32'h0 || done !== 1'b0) begin
            fails++;
            $display("FAIL R1 reset actual=%h/%0b expected=0/0", status, done);
        end
        // R1 eof outside a frame: no pulse, status held
        idle(); eof = 1; idle(); idle();
        frame("R2", 100, 8'h00, 16'h0800, -1, 0, 0, 1, 1, 0, 0, 1);
        frame("R1", 0, 8'h00, 0, -1, 0, 0, 1, 1, 0, 0, 0);
        idle(); eof = 1; idle(); idle();
        frame("R4", 63, 8'h00, 16'h0800, -1, 0, 0, 0, 1, 0, 1, 0);
        frame("R4", 64, 8'h00, 16'h0800, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R4", 1518, 8'h00, 16'h0800, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R4", 1519, 8'h00, 16'h0800, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R5", 200, 8'h00, 16'h0800, 64, 0, 0, 1, 1, 0, 0, 0);
        frame("R5", 200, 8'h00, 16'h0800, 65, 0, 0, 1, 1, 0, 0, 0);
        frame("R5", 40, 8'h00, 16'h0800, 10, 0, 0, 1, 1, 0, 0, 0);
        frame("R6", 13, 8'h00, 16'h0600, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R6", 14, 8'h00, 16'h0600, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R6", 80, 8'h00, 1500, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R6", 80, 8'h00, 1501, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R7", 80, 8'h00, 16'h0800, -1, 0, 0, 0, 1, 0, 0, 0);
        frame("R8", 64, 8'h00, 16'h0800, -1, 0, 0, 1, 0, 0, 1, 0);
        frame("R8", 63, 8'h00, 16'h0800, -1, 0, 0, 1, 0, 0, 1, 0);
        frame("R8", 90, 8'h00, 16'h0800, -1, 0, 0, 1, 0, 0, 0, 0);
        frame("R8", 90, 8'h00, 16'h0800, -1, 0, 0, 1, 1, 0, 1, 0);
        frame("R9", 90, 8'h00, 16'h0800, -1, 0, 0, 1, 1, 1, 0, 0);
        frame("R10", 70, 8'h01, 16'h0800, -1, 1, 1, 1, 1, 0, 0, 1);
        frame("R10", 70, 8'h02, 16'h0800, -1, 0, 0, 1, 1, 0, 0, 0);
        frame("R3", 16400, 8'h00, 16'h0800, -1, 0, 0, 1, 1, 0, 0, 0);
        repeat (4) idle();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule